// File: doc/BRIEF.md
# Receive Destination Filter with Speculative Frame Store

This block sits behind a receive byte parser. Every frame byte is written into a circular store the moment it arrives. The bytes wait there until the filter has made a keep-or-discard decision for the frame. The destination address bytes are collected as they pass. When the parser signals the end of the frame, the filter builds the decision from four sources:

- an eight-entry address table;
- a broadcast policy;
- a group-address policy;
- the frame's error flag and its storage history.

A kept frame is committed as a whole, and the read side then streams it to a downstream switch port with start and end markers. A discarded frame is rolled back: the write pointer returns to the frame's first slot, and no byte of it ever reaches the output.

The table and the two policy bits are loaded through a simple write port. Each table entry holds a valid bit, a drop bit and a 48-bit address. A frame that does not fit in the free space is discarded, and a wrapping counter records each such loss.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `out_vld` and `ovf_cnt` are 0, every table entry is invalid, and both policies pass frames.
- R2: A kept frame leaves on `out_data` byte for byte in arrival order, on consecutive cycles. `out_sof` is high only on its first byte and `out_eof` only on its last. `out_sof` and `out_eof` never assert without `out_vld`.
- R3: No byte of a frame appears on the output before its `in_eop` pulse has been sampled. No byte of a discarded frame ever appears.
- R4: A frame whose destination equals the address of a valid entry with its drop bit set is discarded. A hit on a valid entry with drop clear is kept. A frame whose address matches only an invalid entry, or no entry at all, is kept.
- R5: A destination of all ones is discarded when the broadcast policy bit is 1 and kept when it is 0.
- R6: When the group policy bit is 1, a destination whose first byte has bit 0 set is discarded, unless the destination is all ones. A destination with that bit clear is unaffected by the group policy.
- R7: A frame whose `in_err` is high together with `in_eop` is discarded, whatever the table says.
- R8: A discarded frame releases all of its storage. Any number of discarded frames in a row leaves the full store free for the next frame.
- R9: A frame with a byte that arrives while the store is full is discarded, and `ovf_cnt` increases by exactly 1 at its `in_eop`. Frames that follow are handled normally.
- R10: A frame that delivered fewer than six destination bytes (bytes with `in_da` high) by its `in_eop` is discarded.
- R11: Frames sent back to back (the next frame's first byte in the cycle after `in_eop`) are each output with their own `out_sof` and `out_eof`.
- R12: The first destination byte received is compared with bits 47:40 of a table address, and the sixth with bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tbl_we | input | 1 | Write one table entry |
| cfg_tbl_idx | input | $clog2(N_ENT) | Entry index |
| cfg_tbl_valid | input | 1 | Entry valid bit |
| cfg_tbl_drop | input | 1 | Entry drop bit (1 = discard on hit) |
| cfg_tbl_mac | input | 48 | Entry address; bits 47:40 are the first byte on the wire |
| cfg_pol_we | input | 1 | Write both policy bits |
| cfg_pol_bcast_drop | input | 1 | Discard all-ones destinations |
| cfg_pol_mcast_drop | input | 1 | Discard other group destinations |
| in_vld | input | 1 | Byte strobe from the parser |
| in_data | input | 8 | Frame byte |
| in_da | input | 1 | Marks a byte as part of the destination address |
| in_eop | input | 1 | End of frame pulse, on a cycle without a byte |
| in_err | input | 1 | Frame error, qualified by `in_eop` |
| out_vld | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| ovf_cnt | output | CNT_W | Frames lost to a full store |

## Verification
The hardest case to reach from the ports is the pointer rollback. A discarded frame produces nothing at the output, so a broken rewind stays invisible until the store runs out of space. The stimulus therefore sends a run of error-flagged frames whose total length is several times the store depth. It then sends one kept frame and requires that frame to come out intact with the overflow count unchanged. A separate oversized frame, longer than the whole store, drives the full condition on purpose. That test confirms the counter step and that the frame after it is still handled normally.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int MAC_W    = 48;
  localparam int DA_BYTES = 6;

  typedef struct packed {
    logic             vld;
    logic             drop;
    logic [MAC_W-1:0] mac;
  } cam_ent_t;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_BODY = 2'd1,
    FS_OVF  = 2'd2
  } fstate_t;
endpackage

// File: rtl/rxaf_cam.sv
module rxaf_cam
  import rxaf_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  cam_ent_t         wr_ent,
  input  logic [MAC_W-1:0] key,
  output logic             hit_drop
);
  logic [N_ENT-1:0] drop_hit_vec;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    cam_ent_t ent_q, ent_d;
    logic     ent_en;

    always_comb begin
      ent_en = wr_en && (wr_idx == IDX_W'(g));
      ent_d  = ent_q;
      if (ent_en) ent_d = wr_ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_en) begin
        ent_q <= ent_d;
      end
    end

    assign drop_hit_vec[g] = ent_q.vld && ent_q.drop && (ent_q.mac == key);
  end

  assign hit_drop = |drop_hit_vec;
endmodule

// File: rtl/rxaf_ctl.sv
module rxaf_ctl
  import rxaf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [7:0]       in_data,
  input  logic             in_da,
  input  logic             in_eop,
  input  logic             in_err,
  input  logic             pol_we,
  input  logic             pol_bcast,
  input  logic             pol_mcast,
  input  logic             full,
  input  logic             hit_drop,
  output logic [MAC_W-1:0] da_mac,
  output logic             wr_en,
  output logic             commit,
  output logic             rollback,
  output logic [CNT_W-1:0] ovf_cnt
);
  fstate_t          st_q, st_d;
  logic [MAC_W-1:0] da_q, da_d;
  logic [2:0]       dcnt_q, dcnt_d;
  logic             pb_q, pm_q;
  logic [CNT_W-1:0] ocnt_d;
  logic             byte_in, da_take, is_bc, is_grp, drop_any, ovf_inc;

  always_comb begin
    byte_in = in_vld && !in_eop;
    st_d    = st_q;
    unique case (st_q)
      FS_IDLE: if (!in_eop && byte_in) st_d = full ? FS_OVF : FS_BODY;
      FS_BODY: if (in_eop) st_d = FS_IDLE;
               else if (byte_in && full) st_d = FS_OVF;
      FS_OVF:  if (in_eop) st_d = FS_IDLE;
      default: st_d = FS_IDLE;
    endcase

    wr_en   = byte_in && !full && (st_q != FS_OVF);

    da_take = byte_in && in_da && (dcnt_q != 3'(DA_BYTES));
    da_d    = da_take ? {da_q[MAC_W-9:0], in_data} : da_q;
    dcnt_d  = in_eop ? 3'd0 : (da_take ? dcnt_q + 3'd1 : dcnt_q);

    is_bc    = &da_q;
    is_grp   = da_q[MAC_W-8];
    drop_any = (st_q == FS_OVF) || in_err || (dcnt_q != 3'(DA_BYTES)) ||
               (is_bc && pb_q) || (is_grp && !is_bc && pm_q) || hit_drop;
    commit   = in_eop && (st_q == FS_BODY) && !drop_any;
    rollback = in_eop && !commit;
    ovf_inc  = in_eop && (st_q == FS_OVF);
    ocnt_d   = ovf_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      da_q   <= '0;
      dcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      dcnt_q <= dcnt_d;
      if (da_take) da_q <= da_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pb_q <= 1'b0;
      pm_q <= 1'b0;
    end else if (pol_we) begin
      pb_q <= pol_bcast;
      pm_q <= pol_mcast;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_cnt <= '0;
    end else if (ovf_inc) begin
      ovf_cnt <= ocnt_d;
    end
  end

  assign da_mac = da_q;
endmodule

// File: rtl/rxaf_store.sv
module rxaf_store #(
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW,
  localparam int PW = AW + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       commit,
  input  logic       rollback,
  output logic       full,
  output logic       out_vld,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof
);
  logic [7:0]    mem [DEPTH];
  logic          last_flg [DEPTH];
  logic [PW-1:0] wr_q, wr_d, base_q, base_d, com_q, com_d, rd_q, rd_d;
  logic [PW-1:0] wr_prev;
  logic          rd_go, at_start_q, at_start_d;
  logic          rd_last;

  always_comb begin
    full    = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
    wr_prev = wr_q - PW'(1);

    wr_d   = wr_q;
    base_d = base_q;
    com_d  = com_q;
    if (rollback) begin
      wr_d = base_q;
    end else if (commit) begin
      base_d = wr_q;
      com_d  = wr_q;
    end else if (wr_en) begin
      wr_d = wr_q + PW'(1);
    end

    rd_go      = (rd_q != com_q);
    rd_last    = last_flg[rd_q[AW-1:0]];
    rd_d       = rd_go ? rd_q + PW'(1) : rd_q;
    at_start_d = rd_go ? rd_last : at_start_q;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_q[AW-1:0]]      <= wr_data;
      last_flg[wr_q[AW-1:0]] <= 1'b0;
    end else if (commit) begin
      last_flg[wr_prev[AW-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q       <= '0;
      base_q     <= '0;
      com_q      <= '0;
      rd_q       <= '0;
      at_start_q <= 1'b1;
    end else begin
      wr_q       <= wr_d;
      base_q     <= base_d;
      com_q      <= com_d;
      rd_q       <= rd_d;
      at_start_q <= at_start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
      out_sof  <= 1'b0;
      out_eof  <= 1'b0;
    end else begin
      out_vld  <= rd_go;
      out_sof  <= rd_go && at_start_q;
      out_eof  <= rd_go && rd_last;
      if (rd_go) out_data <= mem[rd_q[AW-1:0]];
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int AW    = 6,
  parameter int CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_tbl_we,
  input  logic [$clog2(N_ENT)-1:0] cfg_tbl_idx,
  input  logic                     cfg_tbl_valid,
  input  logic                     cfg_tbl_drop,
  input  logic [47:0]              cfg_tbl_mac,
  input  logic                     cfg_pol_we,
  input  logic                     cfg_pol_bcast_drop,
  input  logic                     cfg_pol_mcast_drop,
  input  logic                     in_vld,
  input  logic [7:0]               in_data,
  input  logic                     in_da,
  input  logic                     in_eop,
  input  logic                     in_err,
  output logic                     out_vld,
  output logic [7:0]               out_data,
  output logic                     out_sof,
  output logic                     out_eof,
  output logic [CNT_W-1:0]         ovf_cnt
);
  cam_ent_t         tbl_wr;
  logic [MAC_W-1:0] da_mac;
  logic             hit_drop, full, wr_en, commit, rollback;

  assign tbl_wr = '{vld: cfg_tbl_valid, drop: cfg_tbl_drop, mac: cfg_tbl_mac};

  rxaf_cam #(.N_ENT(N_ENT)) u_cam (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_tbl_we),
    .wr_idx   (cfg_tbl_idx),
    .wr_ent   (tbl_wr),
    .key      (da_mac),
    .hit_drop (hit_drop)
  );

  rxaf_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .in_data   (in_data),
    .in_da     (in_da),
    .in_eop    (in_eop),
    .in_err    (in_err),
    .pol_we    (cfg_pol_we),
    .pol_bcast (cfg_pol_bcast_drop),
    .pol_mcast (cfg_pol_mcast_drop),
    .full      (full),
    .hit_drop  (hit_drop),
    .da_mac    (da_mac),
    .wr_en     (wr_en),
    .commit    (commit),
    .rollback  (rollback),
    .ovf_cnt   (ovf_cnt)
  );

  rxaf_store #(.AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (in_data),
    .commit   (commit),
    .rollback (rollback),
    .full     (full),
    .out_vld  (out_vld),
    .out_data (out_data),
    .out_sof  (out_sof),
    .out_eof  (out_eof)
  );
endmodule

// File: rtl/rxaf_chk.sv
module rxaf_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_eop,
  input logic             out_vld,
  input logic             out_sof,
  input logic             out_eof,
  input logic [CNT_W-1:0] ovf_cnt
);
  logic open_q, seen_eop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      seen_eop_q <= 1'b0;
    end else begin
      if (out_vld) open_q <= !out_eof;
      if (in_eop) seen_eop_q <= 1'b1;
    end
  end

  // R2
  sof_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_vld);

  // R2
  eof_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_vld);

  // R11
  frame_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !open_q) |-> out_sof);

  // R11
  no_nested_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> !open_q);

  // R3
  no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> seen_eop_q);

  // R9
  ovf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ovf_cnt) |-> (ovf_cnt == CNT_W'($past(ovf_cnt) + 1'b1)));
endmodule

bind rx_addr_filter rxaf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_eop  (in_eop),
  .out_vld (out_vld),
  .out_sof (out_sof),
  .out_eof (out_eof),
  .ovf_cnt (ovf_cnt)
);

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_tbl_we = 0, cfg_tbl_valid = 0, cfg_tbl_drop = 0;
  logic [2:0]  cfg_tbl_idx = '0;
  logic [47:0] cfg_tbl_mac = '0;
  logic        cfg_pol_we = 0, cfg_pol_bcast_drop = 0, cfg_pol_mcast_drop = 0;
  logic        in_vld = 0, in_da = 0, in_eop = 0, in_err = 0;
  logic [7:0]  in_data = '0;
  logic        out_vld, out_sof, out_eof;
  logic [7:0]  out_data;
  logic [7:0]  ovf_cnt;

  int n_chk = 0;
  int n_fail = 0;
  int seed = 0;
  logic [7:0] cap[$];
  logic [1:0] capf[$];
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  rx_addr_filter u0 (.*);

  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      cap.push_back(out_data);
      capf.push_back({out_sof, out_eof});
    end
  end

  // {pad2, req4, keep1, err1, plen8, mac48}
  localparam logic [63:0] VEC [10] = '{
    {2'd0, 4'd4,  1'b0, 1'b0, 8'd5,  48'h02_11_22_33_44_55}, // R4 drop hit
    {2'd0, 4'd4,  1'b1, 1'b0, 8'd7,  48'h02_11_22_33_44_66}, // R4 keep hit
    {2'd0, 4'd4,  1'b1, 1'b0, 8'd3,  48'h02_11_22_33_44_77}, // R4 invalid entry
    {2'd0, 4'd4,  1'b1, 1'b0, 8'd9,  48'h02_11_22_33_44_88}, // R4 miss
    {2'd0, 4'd5,  1'b0, 1'b0, 8'd4,  48'hff_ff_ff_ff_ff_ff}, // R5 broadcast drop
    {2'd0, 4'd6,  1'b1, 1'b0, 8'd6,  48'h01_00_5e_00_00_01}, // R6 group passes
    {2'd0, 4'd7,  1'b0, 1'b1, 8'd8,  48'h02_11_22_33_44_66}, // R7 error drop
    {2'd0, 4'd4,  1'b0, 1'b0, 8'd2,  48'h04_00_00_00_00_01}, // R4 last entry
    {2'd0, 4'd12, 1'b1, 1'b0, 8'd5,  48'h55_44_33_22_11_02}, // R12 reversed order
    {2'd0, 4'd2,  1'b1, 1'b0, 8'd0,  48'h02_11_22_33_44_66}  // R2 no payload
  };

  task automatic cfg_entry(input int idx, input bit v, input bit d, input logic [47:0] mac);
    @(negedge clk);
    cfg_tbl_we = 1; cfg_tbl_idx = 3'(idx); cfg_tbl_valid = v; cfg_tbl_drop = d; cfg_tbl_mac = mac;
    @(negedge clk);
    cfg_tbl_we = 0;
  endtask

  task automatic cfg_policy(input bit b, input bit m);
    @(negedge clk);
    cfg_pol_we = 1; cfg_pol_bcast_drop = b; cfg_pol_mcast_drop = m;
    @(negedge clk);
    cfg_pol_we = 0;
  endtask

  task automatic send(input logic [47:0] mac, input int plen, input bit err, input int nda,
                      input bit keep, input bit chk_early);
    int total = 12 + plen;
    logic [7:0] b;
    for (int i = 0; i < total; i++) begin
      if (i < 6) b = mac[47 - 8*i -: 8];
      else if (i < 12) b = 8'hA0 + 8'(i);
      else b = 8'(seed + i);
      @(negedge clk);
      in_eop = 0; in_err = 0;
      in_vld = 1; in_data = b; in_da = (i < nda);
      if (keep) exp_q.push_back(b);
    end
    seed = seed + 37;
    @(negedge clk);
    if (chk_early) begin
      n_chk++; // R3: nothing out before end of frame
      if (cap.size() != 0) begin
        n_fail++;
        $display("FAIL R3 early output: got %0d bytes, expected 0", cap.size());
      end
    end
    in_vld = 0; in_da = 0; in_eop = 1; in_err = err;
  endtask

  task automatic end_in(input int wait_cyc);
    @(negedge clk);
    in_eop = 0; in_err = 0;
    repeat (wait_cyc) @(negedge clk);
  endtask

  task automatic check_out(input bit keep, input int req, input int blen, input string what);
    bit ok = 1;
    int bad = -1;
    if (keep) begin
      if (cap.size() != exp_q.size()) ok = 0;
      else begin
        for (int i = 0; i < cap.size(); i++) begin
          logic s, e;
          s = (i == 0) || (blen > 0 && i == blen);
          e = (i == cap.size() - 1) || (blen > 0 && i == blen - 1);
          if (cap[i] !== exp_q[i] || capf[i] !== {s, e}) begin
            ok = 0;
            if (bad < 0) bad = i;
          end
        end
      end
    end else if (cap.size() != 0) ok = 0;
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: got %0d bytes, expected %0d bytes (first mismatch at %0d)",
               req, what, cap.size(), keep ? exp_q.size() : 0, bad);
    end
    cap.delete(); capf.delete(); exp_q.delete();
  endtask

  task automatic frame(input logic [47:0] mac, input int plen, input bit err, input int nda,
                       input bit keep, input int req, input string what);
    send(mac, plen, err, nda, keep, 1'b1);
    end_in(plen + 30);
    check_out(keep, req, 0, what);
  endtask

  task automatic check_cnt(input int req, input int expv);
    n_chk++;
    if (ovf_cnt !== 8'(expv)) begin
      n_fail++;
      $display("FAIL R%0d ovf_cnt: got %0d, expected %0d", req, ovf_cnt, expv);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    n_chk++;
    if (out_vld !== 1'b0) begin
      n_fail++; $display("FAIL R1 out_vld: got %b, expected 0", out_vld);
    end
    check_cnt(1, 0);
    // R1 empty table and pass-all policy
    frame(48'h02_11_22_33_44_55, 4, 0, 6, 1, 1, "empty table keeps");
    frame(48'hff_ff_ff_ff_ff_ff, 4, 0, 6, 1, 1, "default policy keeps broadcast");

    cfg_entry(0, 1, 1, 48'h02_11_22_33_44_55);
    cfg_entry(1, 1, 0, 48'h02_11_22_33_44_66);
    cfg_entry(2, 0, 1, 48'h02_11_22_33_44_77);
    cfg_entry(7, 1, 1, 48'h04_00_00_00_00_01);
    cfg_policy(1, 0);

    for (int v = 0; v < 10; v++) begin
      logic [63:0] w;
      w = VEC[v];
      frame(w[47:0], int'(w[55:48]), w[56], 6, w[57], int'(w[61:58]), $sformatf("vector %0d", v));
    end

    // R6 group policy on
    cfg_policy(0, 1);
    frame(48'h01_00_5e_00_00_01, 5, 0, 6, 0, 6, "group dropped");
    frame(48'h02_11_22_33_44_88, 5, 0, 6, 1, 6, "unicast unaffected");
    frame(48'hff_ff_ff_ff_ff_ff, 5, 0, 6, 1, 5, "broadcast kept with bcast policy off");

    // R10 short destination
    frame(48'h02_11_22_33_44_88, 5, 0, 4, 0, 10, "short destination");

    // R8 rollback reclaims space: 10 x 22 bytes dropped into a 64 byte store
    for (int k = 0; k < 10; k++) frame(48'h02_11_22_33_44_88, 10, 1, 6, 0, 8, "error frame");
    frame(48'h02_11_22_33_44_88, 40, 0, 6, 1, 8, "kept after rollbacks");
    check_cnt(8, 0);

    // R9 overflow
    frame(48'h02_11_22_33_44_88, 70, 0, 6, 0, 9, "oversized frame");
    check_cnt(9, 1);
    frame(48'h02_11_22_33_44_66, 20, 0, 6, 1, 9, "frame after overflow");

    // R11 back to back
    send(48'h02_11_22_33_44_66, 3, 0, 6, 1, 1'b1);
    send(48'h02_11_22_33_44_88, 5, 0, 6, 1, 1'b0);
    end_in(40);
    check_out(1, 11, 15, "back to back");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule